// File: doc/BRIEF.md
# Dual-Path Tagged Instruction Decoder

This block decodes a toy variable-length instruction stream. The fetch side presents a five-byte window together with the address of its first byte. An instruction is 1 to 4 bytes long, and its length is carried in the top two bits of its first byte. The block has two ways to decode a window.

The first is a careful three-stage path. It reads the length field and always produces a correct result: one instruction for every three cycles. When it finishes, it trains a small direct-mapped table with the length it found at that address.

The second is a fast path. It consults the table and trusts the stored lengths without reading any length field. It then reports the first instruction, plus the one that follows it when both addresses are known, in the next cycle.

The fetcher advances its address by the reported lengths. It may only offer a new window while `fetch_ready` is high. A one-cycle `flush` forgets every learned length, for example after the code in memory changes.

Top module: `dual_path_decoder`

## Requirements
- R1: After reset, `fetch_ready` is 1 and `dec_valid` is 0.
- R2: The careful path decodes the byte at offset 0 of the window. Its length is bits [7:6] plus one, giving 1 to 4, and its opcode output is the whole byte. On the fast path, slot 0 is the instruction at `fetch_addr` and slot 1 is the instruction starting at byte offset len0 of the window. Slot 0 occupies bits [7:0] of `dec_op` and [2:0] of `dec_len`; slot 1 occupies bits [15:8] and [5:3].
- R3: A window accepted without a table hit takes the careful path. `fetch_ready` is low for the two cycles after the accepting edge. Slot 0 alone is valid in the cycle after the second edge following acceptance. This gives at most one instruction per three cycles.
- R4: The careful path writes the length for its address into the table, so a later fetch of that address hits.
- R5: A hit on `fetch_addr` gives a valid slot 0 in the cycle after the accepting edge, and `fetch_ready` stays high. Windows can therefore be accepted back to back.
- R6: Slot 1 is valid exactly when the address `fetch_addr`+len0 also hits. Slot 1 is never valid without slot 0.
- R7: When `fetch_addr` hits but the following address misses, only slot 0 is valid and no careful decode is started.
- R8: The table index is the low IDXW address bits and the upper bits are compared. An address that aliases a trained one misses, and its careful decode evicts the earlier entry.
- R9: A flush invalidates every table entry on the next edge.
- R10: A window accepted while `flush` is high is treated as a miss and decoded on the careful path, which then retrains that entry.
- R11: `dec_valid` is a one-cycle pulse per decode, and is 0 in cycles with no result.
- R12: The fast path reports the stored length, not the window's length field. A stale entry therefore yields the trained length until it is flushed or evicted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all learned lengths |
| fetch_valid | input | 1 | Window offered this cycle |
| fetch_addr | input | AW | Address of window byte 0 |
| fetch_bytes | input | 40 | Window, byte k in bits [8k+7:8k] |
| fetch_ready | output | 1 | Window can be accepted this cycle |
| dec_valid | output | 2 | Per-slot result valid |
| dec_op | output | 16 | Per-slot first instruction byte |
| dec_len | output | 6 | Per-slot length, 1 to 4 |

## Verification
A fast-path result is due one edge after the accepting edge. A careful-path result is due two edges later, after two cycles with `fetch_ready` low. Each scenario task drives a window on a falling edge and returns on the falling edge that follows acceptance. It then samples once per falling edge, so every check lands on a known cycle count from the stimulus. The check in the cycle after each result confirms that the pulse has ended. For flush and aliasing, the effect is observed through the latency and the `fetch_ready` pattern of the next fetch.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
   localparam int LFW    = 2;              // length field width in first byte
   localparam int MAXLEN = 1 << LFW;       // longest instruction in bytes
   localparam int LENW   = LFW + 1;        // width of a decoded length
   localparam int WIN    = MAXLEN + 1;     // window bytes needed by two slots

   function automatic logic [LENW-1:0] fld2len(input logic [LFW-1:0] f);
      return LENW'(f) + LENW'(1);
   endfunction
endpackage

// File: rtl/dpd_tag_array.sv
module dpd_tag_array
   import dpd_pkg::*;
#(
   parameter int AW   = 16,
   parameter int IDXW = 4,
   parameter int NRD  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [NRD*AW-1:0] rd_addr,
   output logic [NRD-1:0]    rd_hit,
   output logic [NRD*LFW-1:0] rd_fld,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [LFW-1:0]    wr_fld
);
   localparam int DEPTH = 1 << IDXW;
   localparam int TAGW  = AW - IDXW;

   if (IDXW < 1 || IDXW >= AW) begin : g_bad_idx
      $error("dpd_tag_array: IDXW must be in 1..AW-1");
   end
   if (NRD < 1) begin : g_bad_nrd
      $error("dpd_tag_array: NRD must be at least 1");
   end

   logic [DEPTH-1:0] vld_q;
   logic [TAGW-1:0]  tag_q [DEPTH];
   logic [LFW-1:0]   fld_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             vld_q <= '0;
      else if (flush)         vld_q <= '0;
      else if (wr_en)         vld_q[wr_addr[IDXW-1:0]] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en && !flush) begin
         tag_q[wr_addr[IDXW-1:0]] <= wr_addr[AW-1:IDXW];
         fld_q[wr_addr[IDXW-1:0]] <= wr_fld;
      end
   end

   for (genvar g = 0; g < NRD; g++) begin : g_rd
      logic [AW-1:0] a;
      assign a = rd_addr[g*AW +: AW];
      assign rd_hit[g] = !flush && vld_q[a[IDXW-1:0]]
                         && (tag_q[a[IDXW-1:0]] == a[AW-1:IDXW]);
      assign rd_fld[g*LFW +: LFW] = fld_q[a[IDXW-1:0]];
   end

   AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (vld_q == '0)); // R9
   AST_WRITE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !flush) |=> vld_q[$past(wr_addr[IDXW-1:0])]); // R4
endmodule

// File: rtl/dpd_slow_path.sv
module dpd_slow_path
   import dpd_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [AW-1:0]  start_addr,
   input  logic [7:0]     start_byte,
   output logic           busy,
   output logic           done,
   output logic [AW-1:0]  done_addr,
   output logic [7:0]     done_op,
   output logic [LFW-1:0] done_fld
);
   logic           v1_q, v2_q;
   logic [AW-1:0]  a1_q, a2_q;
   logic [7:0]     b1_q, op2_q;
   logic [LFW-1:0] fld2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1_q <= 1'b0;
         v2_q <= 1'b0;
      end else begin
         v1_q <= start;
         v2_q <= v1_q;
      end
   end

   always_ff @(posedge clk) begin
      if (start) begin
         a1_q <= start_addr;
         b1_q <= start_byte;
      end
      if (v1_q) begin
         a2_q   <= a1_q;
         fld2_q <= b1_q[7:6];
         op2_q  <= b1_q;
      end
   end

   assign busy      = v1_q | v2_q;
   assign done      = v2_q;
   assign done_addr = a2_q;
   assign done_op   = op2_q;
   assign done_fld  = fld2_q;

   AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      v1_q |=> done); // R3
   AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !start); // R3
endmodule

// File: rtl/dual_path_decoder.sv
module dual_path_decoder
   import dpd_pkg::*;
#(
   parameter int AW   = 16,
   parameter int IDXW = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             fetch_valid,
   input  logic [AW-1:0]    fetch_addr,
   input  logic [8*WIN-1:0] fetch_bytes,
   output logic             fetch_ready,
   output logic [1:0]       dec_valid,
   output logic [15:0]      dec_op,
   output logic [2*LENW-1:0] dec_len
);
   localparam int NLANE = 2;

   if (AW <= IDXW) begin : g_bad_aw
      $error("dual_path_decoder: AW must exceed IDXW");
   end

   logic                 accept;
   logic [NLANE*AW-1:0]  lane_addr;
   logic [NLANE-1:0]     lane_hit;
   logic [NLANE*LFW-1:0] lane_fld;
   logic [LENW-1:0]      len0, len1;
   logic [7:0]           op1;
   logic                 slow_start, slow_busy, slow_done;
   logic [AW-1:0]        slow_addr;
   logic [7:0]           slow_op;
   logic [LFW-1:0]       slow_fld;

   assign accept     = fetch_valid && fetch_ready;
   assign len0       = fld2len(lane_fld[0 +: LFW]);
   assign len1       = fld2len(lane_fld[LFW +: LFW]);
   assign lane_addr[0 +: AW]  = fetch_addr;
   assign lane_addr[AW +: AW] = fetch_addr + AW'(len0);

   always_comb begin
      op1 = fetch_bytes[15:8];
      for (int k = 1; k <= MAXLEN; k++)
         if (len0 == LENW'(k)) op1 = fetch_bytes[8*k +: 8];
   end

   dpd_tag_array #(.AW(AW), .IDXW(IDXW), .NRD(NLANE)) u_tags (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .rd_addr (lane_addr),
      .rd_hit  (lane_hit),
      .rd_fld  (lane_fld),
      .wr_en   (slow_done),
      .wr_addr (slow_addr),
      .wr_fld  (slow_fld)
   );

   assign slow_start = accept && !lane_hit[0];

   dpd_slow_path #(.AW(AW)) u_slow (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (slow_start),
      .start_addr (fetch_addr),
      .start_byte (fetch_bytes[7:0]),
      .busy       (slow_busy),
      .done       (slow_done),
      .done_addr  (slow_addr),
      .done_op    (slow_op),
      .done_fld   (slow_fld)
   );

   assign fetch_ready = !slow_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid <= '0;
         dec_op    <= '0;
         dec_len   <= '0;
      end else if (accept && lane_hit[0]) begin
         dec_valid <= {lane_hit[1], 1'b1};
         dec_op    <= {op1, fetch_bytes[7:0]};
         dec_len   <= {len1, len0};
      end else if (slow_done) begin
         dec_valid <= 2'b01;
         dec_op    <= {8'h00, slow_op};
         dec_len   <= {LENW'(0), fld2len(slow_fld)};
      end else begin
         dec_valid <= '0;
      end
   end

   AST_FAST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && lane_hit[0]) |=> dec_valid[0]); // R5
   AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !lane_hit[0]) |=> !fetch_ready); // R3
   AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid[1] |-> dec_valid[0]); // R6
   AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid[0] |-> (dec_len[LENW-1:0] != '0
                        && dec_len[LENW-1:0] <= LENW'(MAXLEN))); // R2
endmodule

// File: tb/dual_path_decoder_tb.sv
module dual_path_decoder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        fetch_valid = 1'b0;
   logic [15:0] fetch_addr = '0;
   logic [39:0] fetch_bytes = '0;
   logic        fetch_ready;
   logic [1:0]  dec_valid;
   logic [15:0] dec_op;
   logic [5:0]  dec_len;
   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   dual_path_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_valid(fetch_valid),
      .fetch_addr(fetch_addr), .fetch_bytes(fetch_bytes),
      .fetch_ready(fetch_ready), .dec_valid(dec_valid), .dec_op(dec_op),
      .dec_len(dec_len));

   function automatic logic [7:0] mk(input int len, input logic [5:0] op);
      logic [1:0] f;
      f = 2'(len - 1);
      return {f, op};
   endfunction

   function automatic logic [39:0] win(input logic [7:0] b0, b1, b2, b3, b4);
      return {b4, b3, b2, b1, b0};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   // drives one window; returns on the falling edge after the accepting edge
   task automatic drive(input logic [15:0] a, input logic [39:0] b, input bit fl);
      @(negedge clk);
      fetch_valid = 1'b1; fetch_addr = a; fetch_bytes = b; flush = fl;
      @(negedge clk);
      fetch_valid = 1'b0; flush = 1'b0;
   endtask

   task automatic slow_case(input string req, input logic [15:0] a,
                            input logic [39:0] b, input bit fl);
      drive(a, b, fl);
      chk({req, " careful: stall 1"}, {fetch_ready, dec_valid}, 3'b000);
      @(negedge clk);
      chk({req, " careful: stall 2"}, {fetch_ready, dec_valid}, 3'b000);
      @(negedge clk);
      chk({req, " careful: result R3"}, {fetch_ready, dec_valid}, 3'b101);
      chk({req, " careful op R2"}, dec_op[7:0], b[7:0]);
      chk({req, " careful len R2"}, dec_len[2:0], 3'(b[7:6]) + 3'd1);
      @(negedge clk);
      chk({req, " pulse ends R11"}, dec_valid, 2'b00);
   endtask

   task automatic fast_case(input string req, input logic [15:0] a, input logic [39:0] b,
                            input logic [1:0] ev, input logic [2:0] el0,
                            input logic [7:0] eop1, input logic [2:0] el1);
      drive(a, b, 1'b0);
      chk({req, " fast valid R5"}, {fetch_ready, dec_valid}, {1'b1, ev});
      chk({req, " fast op0 R2"}, dec_op[7:0], b[7:0]);
      chk({req, " fast len0 R12"}, dec_len[2:0], el0);
      if (ev[1]) begin
         chk({req, " fast op1 R6"}, dec_op[15:8], eop1);
         chk({req, " fast len1 R6"}, dec_len[5:3], el1);
      end
      @(negedge clk);
      chk({req, " pulse ends R11"}, dec_valid, 2'b00);
   endtask

   task automatic t_reset();
      chk("R1 ready after reset", fetch_ready, 1'b1);
      chk("R1 no valid after reset", dec_valid, 2'b00);
   endtask

   task automatic t_train_and_pair();
      logic [39:0] wa;
      wa = win(mk(3, 6'h05), 8'h11, 8'h22, mk(2, 6'h09), 8'h33);
      slow_case("R3 first miss", 16'h0010, wa, 1'b0);
      fast_case("R4 R7 hit single", 16'h0010, wa, 2'b01, 3'd3, 8'h00, 3'd0);
      slow_case("R3 train follower", 16'h0013, win(mk(2, 6'h09), 8'h33, 0, 0, 0), 1'b0);
      fast_case("R6 pair", 16'h0010, wa, 2'b11, 3'd3, mk(2, 6'h09), 3'd2);
   endtask

   task automatic t_back_to_back();
      @(negedge clk);
      fetch_valid = 1'b1; fetch_addr = 16'h0010;
      fetch_bytes = win(mk(3, 6'h05), 8'h11, 8'h22, mk(2, 6'h09), 8'h33);
      @(negedge clk);
      chk("R5 b2b first", {fetch_ready, dec_valid}, 3'b111);
      fetch_addr = 16'h0013; fetch_bytes = win(mk(2, 6'h09), 8'h33, 0, 0, 0);
      @(negedge clk);
      fetch_valid = 1'b0;
      chk("R5 b2b second", {fetch_ready, dec_valid}, 3'b101);
      chk("R5 b2b second len", dec_len[2:0], 3'd2);
      @(negedge clk);
      chk("R11 b2b idle", dec_valid, 2'b00);
   endtask

   task automatic t_all_lengths();
      for (int L = 1; L <= 4; L++) begin
         logic [15:0] a;
         logic [39:0] w;
         a = 16'h0207 + 16'(L);
         w = win(mk(L, 6'(L + 16)), 8'hA0, 8'hA1, 8'hA2, 8'hA3);
         slow_case("R2 length field", a, w, 1'b0);
         fast_case("R2 length stored", a, w, 2'b01, 3'(L), 8'h00, 3'd0);
      end
   endtask

   task automatic t_stale();
      fast_case("R12 stale length", 16'h0010,
                win(mk(1, 6'h07), 8'h44, 8'h55, mk(2, 6'h09), 8'h66),
                2'b11, 3'd3, mk(2, 6'h09), 3'd2);
   endtask

   task automatic t_alias();
      slow_case("R8 alias misses", 16'h0020, win(mk(1, 6'h2A), 0, 0, 0, 0), 1'b0);
      slow_case("R8 evicted misses", 16'h0010,
                win(mk(3, 6'h05), 8'h11, 8'h22, mk(2, 6'h09), 8'h33), 1'b0);
   endtask

   task automatic t_flush();
      @(negedge clk);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      slow_case("R9 after flush", 16'h0010,
                win(mk(3, 6'h05), 8'h11, 8'h22, mk(2, 6'h09), 8'h33), 1'b0);
   endtask

   task automatic t_flush_same_cycle();
      logic [39:0] wa;
      wa = win(mk(3, 6'h05), 8'h11, 8'h22, mk(2, 6'h09), 8'h33);
      slow_case("R10 fetch with flush", 16'h0010, wa, 1'b1);
      fast_case("R10 retrained", 16'h0010, wa, 2'b01, 3'd3, 8'h00, 3'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_train_and_pair();
      t_back_to_back();
      t_all_lengths();
      t_stale();
      t_alias();
      t_flush();
      t_flush_same_cycle();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #2000000;
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog act=hung exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule